// File: doc/BRIEF.md
# Three-Level Branch Target Predictor

This block sits in the fetch stage and supplies a taken-branch target for each fetch address. The smallest table answers in the same cycle as the fetch address. It is split into two fully associative halves, one for branches that jump forward and one for branches that jump backward. A mid-size table checks that answer one cycle later. A large table checks the mid-size table's answer four cycles after the fetch. Whenever a deeper table disagrees with the answer it checks, the block raises a redirect. The redirect carries the corrected outcome (taken with a target, or fall through) and the number of fetch bubbles that the correction costs.

Resolved taken branches come in on an update port. Each one is written into all three tables: a table that already holds the branch has its target overwritten, and a table that does not hold it gets a new entry. A flush drops every check still in flight, so a stale correction never reaches fetch.

The level-2 table defaults to 256 sets of 7 ways so that elaboration stays small. Setting `L2_SETS` to 1024 gives the full 7168-entry table.

Top module: `tri_level_target_pred`

## Requirements
- R1: While reset is held, and after it is released with no update yet, `pred_hit` and `redir_valid` are 0 and `redir_bubbles` is 0.
- R2: Level 0 is searched with the whole fetch address. When `fetch_valid` is 1 and level 0 holds the address, `pred_hit` is 1 and `pred_target` gives the stored target in that same cycle. Otherwise both are 0.
- R3: An update whose target is strictly below its branch address goes to the backward half of level 0; any other update goes to the forward half. Each half holds 8 entries. A branch address is held in at most one half: installing it in one half removes it from the other.
- R4: Each table keeps a used bit per entry. A write picks the existing matching entry if there is one. Otherwise it picks the lowest-numbered invalid entry, and if none is invalid, the lowest-numbered entry whose used bit is clear. The written entry's used bit is set. If that leaves every used bit in the half or set at 1, all the others are cleared. Only update writes change used bits.
- R5: Level 1 has 128 sets of 4 ways, indexed by address bits [6:0] and tagged by bits [14:7]. Level 2 has sets of 7 ways, indexed by bits [7:0] (default 256 sets) and tagged by bits [15:8]. Each entry holds a valid bit, a partial tag and a target.
- R6: Level 1 checks a fetch one cycle after it is presented. On disagreement, a redirect with `redir_bubbles` = 1 appears in that cycle, and a fetch presented in that cycle is discarded.
- R7: Level 2 checks a fetch four cycles after it is presented, against the level-1 outcome. On disagreement, a redirect with `redir_bubbles` = 4 appears. All younger fetches still in flight are dropped, and a fetch presented in that cycle is discarded.
- R8: Two levels disagree when one hits and the other misses, or when both hit with different targets. When they agree, no redirect is raised.
- R9: `redir_taken` is 1 with `redir_target` = the deeper level's target when that level hits. It is 0 with `redir_target` = 0 when that level misses. `redir_bubbles` is 0 in any cycle without a redirect.
- R10: An update writes the branch into every level in the same clock edge. A lookup sees the write from the next cycle on.
- R11: In a cycle with `flush` = 1, no redirect is raised and every fetch in flight is dropped. A fetch presented in that same cycle is accepted.
- R12: A level-2 correction for a fetch that level 1 already corrected supersedes it. If checks for two fetches disagree in one cycle, only the older fetch's level-2 redirect is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Cancel every check in flight |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_pc | input | 32 | Fetch address |
| pred_hit | output | 1 | Level-0 hit for the current fetch |
| pred_target | output | 32 | Level-0 target, 0 on miss |
| upd_valid | input | 1 | Install a resolved taken branch |
| upd_pc | input | 32 | Branch address being installed |
| upd_target | input | 32 | Resolved target |
| redir_valid | output | 1 | A deeper level overrides an earlier answer |
| redir_taken | output | 1 | Corrected outcome is taken |
| redir_target | output | 32 | Corrected target, 0 when not taken |
| redir_bubbles | output | 3 | Bubble cost: 1 for level 1, 4 for level 2, 0 when idle |

## Verification
Directed sequences cover four disagreement cases. In the first, the two halves of level 0 are filled until a branch survives only in the deeper tables, which separates a level-1 hit-over-miss from agreement. In the second, five branches share one level-1 set, so level 0 hits, level 1 misses and level 2 hits; this produces the fall-through correction followed by the taken correction that supersedes it. In the third, a level-1 partial-tag alias gives two hits with different targets. The fourth puts a flush between a fetch and its level-2 check, which shows whether pending corrections are cancelled. A randomised stream of fetches, updates and flushes over a small address pool with aliasing mixes back-to-back overrides with replacement pressure. A behavioural queue model is compared with the design in every cycle.

// File: rtl/tri_level_target_pred.sv
module tri_level_target_pred #(
  parameter int AW      = 32,
  parameter int L0_N    = 8,
  parameter int L1_SETS = 128,
  parameter int L1_WAYS = 4,
  parameter int L1_TW   = 8,
  parameter int L2_SETS = 256,
  parameter int L2_WAYS = 7,
  parameter int L2_TW   = 8,
  parameter int L2_BUB  = 4,
  localparam int BW     = $clog2(L2_BUB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  output logic          pred_hit,
  output logic [AW-1:0] pred_target,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic [AW-1:0] upd_target,
  output logic          redir_valid,
  output logic          redir_taken,
  output logic [AW-1:0] redir_target,
  output logic [BW-1:0] redir_bubbles
);
  localparam int S1B = $clog2(L1_SETS);
  localparam int S2B = $clog2(L2_SETS);
  localparam int W0B = $clog2(L0_N);
  localparam int W1B = $clog2(L1_WAYS);
  localparam int W2B = $clog2(L2_WAYS);
  localparam int PW  = (S1B + L1_TW > S2B + L2_TW) ? S1B + L1_TW : S2B + L2_TW;

  // table storage
  logic [L0_N-1:0]    l0_v [2];
  logic [L0_N-1:0]    l0_u [2];
  logic [AW-1:0]      l0_tag [2][L0_N];
  logic [AW-1:0]      l0_tgt [2][L0_N];
  logic [L1_WAYS-1:0] l1_v [L1_SETS];
  logic [L1_WAYS-1:0] l1_u [L1_SETS];
  logic [L1_TW-1:0]   l1_tag [L1_SETS][L1_WAYS];
  logic [AW-1:0]      l1_tgt [L1_SETS][L1_WAYS];
  logic [L2_WAYS-1:0] l2_v [L2_SETS];
  logic [L2_WAYS-1:0] l2_u [L2_SETS];
  logic [L2_TW-1:0]   l2_tag [L2_SETS][L2_WAYS];
  logic [AW-1:0]      l2_tgt [L2_SETS][L2_WAYS];

  // check pipeline: stage 1 carries the level-0 answer, later stages the level-1 answer
  logic [L2_BUB:1] s_v, s_hit;
  logic [PW-1:0]   s_pc  [L2_BUB:1];
  logic [AW-1:0]   s_tgt [L2_BUB:1];

  // level-0 lookup, same cycle
  logic            l0_hit;
  logic [AW-1:0]   l0_t;
  logic [2*L0_N-1:0] l0_hv;
  always_comb begin
    l0_hit = 1'b0; l0_t = '0; l0_hv = '0;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < L0_N; i++)
        if (l0_v[p][i] && l0_tag[p][i] == fetch_pc) begin
          l0_hv[p*L0_N+i] = 1'b1; l0_hit = 1'b1; l0_t = l0_tgt[p][i];
        end
  end
  assign pred_hit    = fetch_valid & l0_hit;
  assign pred_target = pred_hit ? l0_t : '0;

  // level-1 check of stage 1
  wire [S1B-1:0]   c1_set = s_pc[1][S1B-1:0];
  wire [L1_TW-1:0] c1_tag = s_pc[1][S1B+L1_TW-1:S1B];
  logic            l1_hit;
  logic [AW-1:0]   l1_t;
  always_comb begin
    l1_hit = 1'b0; l1_t = '0;
    for (int w = 0; w < L1_WAYS; w++)
      if (l1_v[c1_set][w] && l1_tag[c1_set][w] == c1_tag) begin l1_hit = 1'b1; l1_t = l1_tgt[c1_set][w]; end
  end

  // level-2 check of the last stage
  wire [S2B-1:0]   c2_set = s_pc[L2_BUB][S2B-1:0];
  wire [L2_TW-1:0] c2_tag = s_pc[L2_BUB][S2B+L2_TW-1:S2B];
  logic            l2_hit;
  logic [AW-1:0]   l2_t;
  always_comb begin
    l2_hit = 1'b0; l2_t = '0;
    for (int w = 0; w < L2_WAYS; w++)
      if (l2_v[c2_set][w] && l2_tag[c2_set][w] == c2_tag) begin l2_hit = 1'b1; l2_t = l2_tgt[c2_set][w]; end
  end

  wire d1 = s_v[1] && ((l1_hit != s_hit[1]) || (l1_hit && l1_t != s_tgt[1]));
  wire d2 = s_v[L2_BUB] && ((l2_hit != s_hit[L2_BUB]) || (l2_hit && l2_t != s_tgt[L2_BUB]));
  wire fire2 = ~flush & d2;
  wire fire1 = ~flush & d1 & ~fire2;

  assign redir_valid   = fire1 | fire2;
  assign redir_taken   = fire2 ? l2_hit : (fire1 & l1_hit);
  assign redir_target  = !redir_taken ? '0 : (fire2 ? l2_t : l1_t);
  assign redir_bubbles = fire2 ? BW'(L2_BUB) : (fire1 ? BW'(1) : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s_v <= '0;
    else begin
      s_v[1] <= fetch_valid & ~fire1 & ~fire2;
      for (int k = 2; k <= L2_BUB; k++) s_v[k] <= (flush | fire2) ? 1'b0 : s_v[k-1];
    end

  always_ff @(posedge clk) begin
    s_pc[1] <= fetch_pc[PW-1:0]; s_hit[1] <= l0_hit; s_tgt[1] <= l0_t;
    s_pc[2] <= s_pc[1];          s_hit[2] <= l1_hit; s_tgt[2] <= l1_t;
    for (int k = 3; k <= L2_BUB; k++) begin
      s_pc[k] <= s_pc[k-1]; s_hit[k] <= s_hit[k-1]; s_tgt[k] <= s_tgt[k-1];
    end
  end

  // update path: way choice for each level
  wire ub  = upd_target < upd_pc;
  wire nub = ~ub;
  logic            u0_hit;
  logic [W0B-1:0]  u0_way, u0_vic, u0_w;
  logic [L0_N-1:0] u0_clr, u0_unew;
  always_comb begin
    u0_hit = 1'b0; u0_way = '0; u0_vic = '0; u0_clr = '0;
    for (int i = 0; i < L0_N; i++) begin
      if (l0_v[ub][i] && l0_tag[ub][i] == upd_pc) begin u0_hit = 1'b1; u0_way = W0B'(i); end
      if (l0_v[nub][i] && l0_tag[nub][i] == upd_pc) u0_clr[i] = 1'b1;
    end
    for (int i = L0_N-1; i >= 0; i--) if (!l0_u[ub][i]) u0_vic = W0B'(i);
    for (int i = L0_N-1; i >= 0; i--) if (!l0_v[ub][i]) u0_vic = W0B'(i);
    u0_w    = u0_hit ? u0_way : u0_vic;
    u0_unew = l0_u[ub] | (L0_N'(1) << u0_w);
    if (&u0_unew) u0_unew = L0_N'(1) << u0_w;
  end

  wire [S1B-1:0]   u1_set = upd_pc[S1B-1:0];
  wire [L1_TW-1:0] u1_tag = upd_pc[S1B+L1_TW-1:S1B];
  logic               u1_hit;
  logic [W1B-1:0]     u1_way, u1_vic, u1_w;
  logic [L1_WAYS-1:0] u1_unew;
  always_comb begin
    u1_hit = 1'b0; u1_way = '0; u1_vic = '0;
    for (int w = 0; w < L1_WAYS; w++)
      if (l1_v[u1_set][w] && l1_tag[u1_set][w] == u1_tag) begin u1_hit = 1'b1; u1_way = W1B'(w); end
    for (int w = L1_WAYS-1; w >= 0; w--) if (!l1_u[u1_set][w]) u1_vic = W1B'(w);
    for (int w = L1_WAYS-1; w >= 0; w--) if (!l1_v[u1_set][w]) u1_vic = W1B'(w);
    u1_w    = u1_hit ? u1_way : u1_vic;
    u1_unew = l1_u[u1_set] | (L1_WAYS'(1) << u1_w);
    if (&u1_unew) u1_unew = L1_WAYS'(1) << u1_w;
  end

  wire [S2B-1:0]   u2_set = upd_pc[S2B-1:0];
  wire [L2_TW-1:0] u2_tag = upd_pc[S2B+L2_TW-1:S2B];
  logic               u2_hit;
  logic [W2B-1:0]     u2_way, u2_vic, u2_w;
  logic [L2_WAYS-1:0] u2_unew;
  always_comb begin
    u2_hit = 1'b0; u2_way = '0; u2_vic = '0;
    for (int w = 0; w < L2_WAYS; w++)
      if (l2_v[u2_set][w] && l2_tag[u2_set][w] == u2_tag) begin u2_hit = 1'b1; u2_way = W2B'(w); end
    for (int w = L2_WAYS-1; w >= 0; w--) if (!l2_u[u2_set][w]) u2_vic = W2B'(w);
    for (int w = L2_WAYS-1; w >= 0; w--) if (!l2_v[u2_set][w]) u2_vic = W2B'(w);
    u2_w    = u2_hit ? u2_way : u2_vic;
    u2_unew = l2_u[u2_set] | (L2_WAYS'(1) << u2_w);
    if (&u2_unew) u2_unew = L2_WAYS'(1) << u2_w;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin l0_v[p] <= '0; l0_u[p] <= '0; end
      for (int s = 0; s < L1_SETS; s++) begin l1_v[s] <= '0; l1_u[s] <= '0; end
      for (int s = 0; s < L2_SETS; s++) begin l2_v[s] <= '0; l2_u[s] <= '0; end
    end else if (upd_valid) begin
      l0_v[nub] <= l0_v[nub] & ~u0_clr;
      l0_v[ub][u0_w] <= 1'b1;      l0_u[ub]     <= u0_unew;
      l1_v[u1_set][u1_w] <= 1'b1;  l1_u[u1_set] <= u1_unew;
      l2_v[u2_set][u2_w] <= 1'b1;  l2_u[u2_set] <= u2_unew;
    end

  always_ff @(posedge clk)
    if (upd_valid) begin
      l0_tag[ub][u0_w] <= upd_pc;        l0_tgt[ub][u0_w] <= upd_target;
      l1_tag[u1_set][u1_w] <= u1_tag;    l1_tgt[u1_set][u1_w] <= upd_target;
      l2_tag[u2_set][u2_w] <= u2_tag;    l2_tgt[u2_set][u2_w] <= upd_target;
    end

  a_r3_one_half: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(l0_hv));
  a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_bubbles == BW'(L2_BUB)) |=> !redir_valid);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n) flush |-> !redir_valid);
  a_r11_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(redir_valid && redir_bubbles == BW'(L2_BUB)));
  a_r6_source: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_bubbles == BW'(1)) |-> $past(fetch_valid));
endmodule

// File: tb/sim_tri_level_target_pred.sv
module sim_tri_level_target_pred;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, fetch_valid = 1'b0, upd_valid = 1'b0;
  logic [31:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
  logic pred_hit, redir_valid, redir_taken;
  logic [31:0] pred_target, redir_target;
  logic [2:0] redir_bubbles;

  tri_level_target_pred u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_target(pred_target), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_target(upd_target), .redir_valid(redir_valid), .redir_taken(redir_taken),
    .redir_target(redir_target), .redir_bubbles(redir_bubbles));

  always #2 clk = ~clk;

  int errors = 0, checks = 0, seen1 = 0, seen4 = 0;
  string req = "R1";
  bit done = 0;

  // behavioural reference tables
  bit m0v[2][8], m0u[2][8];
  logic [31:0] m0tag[2][8], m0tgt[2][8];
  bit m1v[128][4], m1u[128][4];
  logic [7:0] m1tag[128][4];
  logic [31:0] m1tgt[128][4];
  bit m2v[256][7], m2u[256][7];
  logic [7:0] m2tag[256][7];
  logic [31:0] m2tgt[256][7];

  typedef struct { int age; logic [31:0] pc; bit hit; logic [31:0] tgt; } rec_t;
  rec_t q[$];
  rec_t nq[$];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int vic(int n, logic [7:0] vv, logic [7:0] uu);
    int r = 0;
    for (int i = n-1; i >= 0; i--) if (!uu[i]) r = i;
    for (int i = n-1; i >= 0; i--) if (!vv[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] touch(int n, logic [7:0] uu, int w);
    logic [7:0] full = 8'((1 << n) - 1);
    logic [7:0] r = uu | 8'(1 << w);
    if ((r & full) == full) r = 8'(1 << w);
    return r;
  endfunction

  function automatic void mlook0(input logic [31:0] pc, output bit h, output logic [31:0] t);
    h = 0; t = '0;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 8; i++)
        if (m0v[p][i] && m0tag[p][i] == pc) begin h = 1; t = m0tgt[p][i]; end
  endfunction

  function automatic void mlook1(input logic [31:0] pc, output bit h, output logic [31:0] t);
    h = 0; t = '0;
    for (int w = 0; w < 4; w++)
      if (m1v[pc[6:0]][w] && m1tag[pc[6:0]][w] == pc[14:7]) begin h = 1; t = m1tgt[pc[6:0]][w]; end
  endfunction

  function automatic void mlook2(input logic [31:0] pc, output bit h, output logic [31:0] t);
    h = 0; t = '0;
    for (int w = 0; w < 7; w++)
      if (m2v[pc[7:0]][w] && m2tag[pc[7:0]][w] == pc[15:8]) begin h = 1; t = m2tgt[pc[7:0]][w]; end
  endfunction

  // R3 R4 R10: install into every level
  function automatic void mupd(input logic [31:0] pc, input logic [31:0] tg);
    int b = (tg < pc) ? 1 : 0;
    int hw; int w; logic [7:0] vv, uu;
    hw = -1;
    for (int i = 0; i < 8; i++) begin
      if (m0v[b][i] && m0tag[b][i] == pc) hw = i;
      if (m0v[1-b][i] && m0tag[1-b][i] == pc) m0v[1-b][i] = 0;
    end
    for (int i = 0; i < 8; i++) begin vv[i] = m0v[b][i]; uu[i] = m0u[b][i]; end
    w = (hw >= 0) ? hw : vic(8, vv, uu);
    uu = touch(8, uu, w);
    m0v[b][w] = 1; m0tag[b][w] = pc; m0tgt[b][w] = tg;
    for (int i = 0; i < 8; i++) m0u[b][i] = uu[i];

    hw = -1; vv = '0; uu = '0;
    for (int i = 0; i < 4; i++) begin
      if (m1v[pc[6:0]][i] && m1tag[pc[6:0]][i] == pc[14:7]) hw = i;
      vv[i] = m1v[pc[6:0]][i]; uu[i] = m1u[pc[6:0]][i];
    end
    w = (hw >= 0) ? hw : vic(4, vv, uu);
    uu = touch(4, uu, w);
    m1v[pc[6:0]][w] = 1; m1tag[pc[6:0]][w] = pc[14:7]; m1tgt[pc[6:0]][w] = tg;
    for (int i = 0; i < 4; i++) m1u[pc[6:0]][i] = uu[i];

    hw = -1; vv = '0; uu = '0;
    for (int i = 0; i < 7; i++) begin
      if (m2v[pc[7:0]][i] && m2tag[pc[7:0]][i] == pc[15:8]) hw = i;
      vv[i] = m2v[pc[7:0]][i]; uu[i] = m2u[pc[7:0]][i];
    end
    w = (hw >= 0) ? hw : vic(7, vv, uu);
    uu = touch(7, uu, w);
    m2v[pc[7:0]][w] = 1; m2tag[pc[7:0]][w] = pc[15:8]; m2tgt[pc[7:0]][w] = tg;
    for (int i = 0; i < 7; i++) m2u[pc[7:0]][i] = uu[i];
  endfunction

  always @(negedge clk) begin : mdl
    bit h0, h1, h2, d1, f1, f2, eh, et_k;
    logic [31:0] t0, t1, t2, et, er_t;
    logic [2:0] eb;
    if (!rst_n) begin
      foreach (m0v[p, i]) begin m0v[p][i] = 0; m0u[p][i] = 0; end
      foreach (m1v[s, w]) begin m1v[s][w] = 0; m1u[s][w] = 0; end
      foreach (m2v[s, w]) begin m2v[s][w] = 0; m2u[s][w] = 0; end
      q.delete();
      chk(pred_hit == 0 && redir_valid == 0 && redir_bubbles == 0, "R1 reset outputs",
          {pred_hit, redir_valid, redir_bubbles}, 0);
    end else begin
      mlook0(fetch_pc, h0, t0);
      eh = fetch_valid && h0;
      et = eh ? t0 : '0;
      d1 = 0; f2 = 0; h1 = 0; t1 = '0; h2 = 0; t2 = '0;
      foreach (q[i]) begin
        if (q[i].age == 4) begin
          mlook2(q[i].pc, h2, t2);
          if (h2 != q[i].hit || (h2 && t2 != q[i].tgt)) f2 = 1;
        end
        if (q[i].age == 1) begin
          mlook1(q[i].pc, h1, t1);
          if (h1 != q[i].hit || (h1 && t1 != q[i].tgt)) d1 = 1;
        end
      end
      if (flush) f2 = 0;
      f1 = d1 && !f2 && !flush;
      et_k = f2 ? h2 : (f1 && h1);
      er_t = !et_k ? '0 : (f2 ? t2 : t1);
      eb = f2 ? 3'd4 : (f1 ? 3'd1 : 3'd0);
      // R2 zero-bubble answer
      chk(pred_hit === eh && pred_target === et, "R2 level-0 prediction",
          {31'd0, pred_hit, pred_target}, {31'd0, eh, et});
      // R6 R7 R8 R9 R12 redirect
      chk(redir_valid === (f1 | f2) && redir_taken === et_k && redir_target === er_t && redir_bubbles === eb,
          "R9 redirect fields", {27'd0, redir_valid, redir_taken, redir_bubbles, redir_target},
          {27'd0, (f1 | f2), et_k, eb, er_t});
      if (redir_valid && redir_bubbles == 1) seen1++;
      if (redir_valid && redir_bubbles == 4) seen4++;
      // advance the reference pipeline
      if (flush || f2) q.delete();
      else begin
        nq.delete();
        foreach (q[i]) begin
          if (q[i].age == 1) begin q[i].hit = h1; q[i].tgt = t1; end
          if (q[i].age < 4) nq.push_back(q[i]);
        end
        q = nq;
      end
      foreach (q[i]) q[i].age++;
      if (fetch_valid && !f1 && !f2) q.push_back('{1, fetch_pc, h0, t0});
      if (upd_valid) mupd(upd_pc, upd_target);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    fetch_valid = 0; upd_valid = 0; flush = 0;
  endtask
  task automatic do_upd(input logic [31:0] pc, input logic [31:0] tg);
    upd_valid = 1; upd_pc = pc; upd_target = tg; cyc();
  endtask
  task automatic do_fetch(input logic [31:0] pc);
    fetch_valid = 1; fetch_pc = pc; cyc();
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s1, s4;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    req = "R1"; repeat (2) cyc();

    req = "R10"; do_upd(32'h1000, 32'h1400);
    req = "R8";  do_fetch(32'h1000); repeat (5) cyc();
    req = "R3";  do_upd(32'h2040, 32'h2000); do_fetch(32'h2040); repeat (5) cyc();

    // R4: eight more forward branches push 0x1000 out of level 0 only
    req = "R4";
    for (int i = 1; i <= 8; i++) do_upd(32'h4000 + i * 32'h10, 32'h4100 + i * 32'h10);
    s1 = seen1;
    req = "R6"; do_fetch(32'h1000); do_fetch(32'h2040); repeat (5) cyc();
    chk(seen1 == s1 + 1, "R6 level-1 redirect count", 64'(seen1 - s1), 1);

    // R5 R12: five branches share one level-1 set
    req = "R5";
    for (int i = 0; i < 5; i++) do_upd(32'h3005 + i * 32'h80, 32'h3045 + i * 32'h80);
    s1 = seen1; s4 = seen4;
    req = "R12"; do_fetch(32'h3005); repeat (6) cyc();
    chk(seen1 == s1 + 1 && seen4 == s4 + 1, "R12 fall-through then taken",
        64'({seen1 - s1, seen4 - s4}), 64'({32'd1, 32'd1}));

    // R11: flush between fetch and level-2 check
    req = "R11"; s4 = seen4;
    do_fetch(32'h3005); cyc();
    flush = 1; fetch_valid = 1; fetch_pc = 32'h1000; cyc();
    repeat (6) cyc();
    chk(seen4 == s4, "R11 level-2 redirect cancelled", 64'(seen4 - s4), 0);

    // R8: target disagreement through a level-1 alias
    req = "R10"; do_upd(32'h1000, 32'h1800); do_fetch(32'h1000); repeat (5) cyc();
    req = "R8";  do_upd(32'h9000, 32'h9100); s4 = seen4;
    do_fetch(32'h1000); repeat (6) cyc();
    chk(seen4 == s4 + 1, "R8 differing targets", 64'(seen4 - s4), 1);

    // R7: back-to-back mixed stream
    req = "R7";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] p;
      p = ((32'($urandom % 2)) << 15) | (32'h5000 + 32'($urandom % 24) * 32'h84);
      fetch_valid = ($urandom % 10) < 7; fetch_pc = p;
      if (($urandom % 10) < 3) begin
        upd_valid = 1;
        upd_pc = ((32'($urandom % 2)) << 15) | (32'h5000 + 32'($urandom % 24) * 32'h84);
        upd_target = ($urandom % 2) ? upd_pc + 32'h200 : upd_pc - 32'h100;
      end
      flush = ($urandom % 33) == 0;
      cyc();
    end
    repeat (6) cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule